// File: doc/BRIEF.md
# SAR Converter Sequencer and Serial Read Port

This block is the digital half of a 12-bit successive-approximation converter. A behavioural SAR core delivers a finished code, and this block decides when a conversion starts and how long it runs. It also picks the power state and the read framing, and returns the stored code over a three-wire serial port with a tri-state data line. The three external pins (an active-low start, an active-low select and the serial clock) are brought into the system clock domain through two-flop synchronisers. Every edge is detected on the synchronised copies.

A conversion lasts a fixed number of system clocks. When it ends, the block samples two pin levels. The start pin decides whether the block goes to sleep. The select pin decides whether the read that follows uses busy framing: in that framing the data line is pulled low when the conversion ends, and the MSB comes on the first serial clock fall. In the other framing the MSB appears as soon as select falls. A read cut short after a small number of clock cycles is taken as a command, and the block acts on it at the next conversion end. That command clears the result and the modes. A result is flagged valid only after the first such command since power-on.

Top module: `sar_ctl_serial`

## Requirements
- R1: After reset the data line is released (`sdo_oe`=0, `sdo_bit`=0), no conversion is running, the block is awake and `res_valid`=0.
- R2: A falling edge of `conv_n` while the block is awake and idle starts a conversion. `conv_active` then stays high for CONV_CYC clocks, and at its end the code from `core_code` is stored unchanged as straight binary.
- R3: At conversion end, a low `conv_n` sends the block to sleep (`pd_state`=1). A high `conv_n` keeps it awake (`pd_state`=0).
- R4: While asleep, a rising edge of `conv_n` begins a wake-up interval of PU_CYC clocks. Start edges during sleep or wake-up are ignored, and after the interval a start edge is accepted again.
- R5: The serial port still works during sleep, so the stored code can be read back.
- R6: If `cs_n` is low at conversion end, the data line is driven 0 at conversion end. Serial clock falls 1 to 12 then present bits 11 down to 0, and fall 13 releases the line.
- R7: If `cs_n` is high at conversion end, a later `cs_n` fall (outside a conversion) drives bit 11. Serial clock falls 1 to 11 present bits 10 down to 0, and fall 12 releases the line.
- R8: A rising edge of `cs_n` always releases the data line.
- R9: If `cs_n` rises after 2 to 8 serial clock falls (inclusive) in the current frame, a reset command is armed. A frame with 9 or more falls arms nothing. At the next conversion end the armed command clears the stored code to 0, selects the awake state and normal framing (no drive at conversion end), and discards that conversion's code.
- R10: `res_valid` goes high at a conversion end only when a reset command has already executed since power-on. The conversion end that executes the command leaves `res_valid` at 0.
- R11: Serial clock falls while `cs_n` is high have no effect on the data line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_n | input | 1 | Conversion start, active low, edge triggered, asynchronous |
| cs_n | input | 1 | Serial select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| core_code | input | CODE_W | Finished code from the SAR core |
| sdo_oe | output | 1 | Data line enable (0 = high impedance) |
| sdo_bit | output | 1 | Data line value when enabled |
| conv_active | output | 1 | Conversion in progress |
| pd_state | output | 1 | Asleep or waking up |
| res_valid | output | 1 | Stored code is flagged valid |

## Verification
Every cycle, assertions check the following:
- sleep is entered only straight after a conversion end;
- no conversion starts during wake-up;
- a conversion never runs past its length;
- a select rise always releases the line;
- a frame never outlasts its bit count;
- the reset command arms only inside its window and always clears the code.

Only the bench scenarios can show the actual bit order under both framings, the read during sleep, the exact boundaries of the abort window at 2 and 9 falls, and the valid flag appearing only after a command.

// File: rtl/sarc_pkg.sv
package sarc_pkg;

  typedef enum logic [1:0] {
    PW_READY = 2'd0,
    PW_CONV  = 2'd1,
    PW_SLEEP = 2'd2,
    PW_WAKE  = 2'd3
  } pwr_state_e;

  // Index of the code bit presented after a given number of serial falls.
  function automatic int unsigned frame_bit(input logic busy_frame,
                                            input int unsigned falls,
                                            input int unsigned width);
    int unsigned top;
    top = busy_frame ? width : width - 1;
    if (falls > top) return 0;
    return top - falls;
  endfunction

  // Serial fall count that ends a frame and releases the line.
  function automatic int unsigned frame_last(input logic busy_frame,
                                             input int unsigned width);
    return busy_frame ? width + 1 : width;
  endfunction

endpackage

// File: rtl/sarc_sync.sv
module sarc_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] IDLE_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] lvl,
  output logic [W-1:0] tgl
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= IDLE_VAL;
        else if (s == 0) stage_q[s] <= async_in;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE_VAL;
    else prev_q <= stage_q[STAGES-1];
  end

  assign lvl = stage_q[STAGES-1];
  assign tgl = stage_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/sarc_conv_ctrl.sv
module sarc_conv_ctrl
  import sarc_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int CONV_CYC = 33,
  parameter int PU_CYC = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_lvl,
  input  logic              conv_fall,
  input  logic              conv_rise,
  input  logic              cs_lvl,
  input  logic              srst_armed,
  input  logic [CODE_W-1:0] core_code,
  output logic              eoc,
  output logic              eoc_busy,
  output logic              srst_exec,
  output logic [CODE_W-1:0] result,
  output logic              valid,
  output logic              active,
  output logic              sleeping
);
  localparam int MAXC = (CONV_CYC > PU_CYC) ? CONV_CYC : PU_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYC - 1);
  localparam logic [CNT_W-1:0] WAKE_LAST = CNT_W'(PU_CYC - 1);

  pwr_state_e st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic seen_cmd_q;

  assign eoc       = (st_q == PW_CONV) && (cnt_q == CONV_LAST);
  assign srst_exec = eoc && srst_armed;
  assign eoc_busy  = eoc && !srst_armed && !cs_lvl;
  assign active    = (st_q == PW_CONV);
  assign sleeping  = (st_q == PW_SLEEP) || (st_q == PW_WAKE);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      PW_READY: if (conv_fall) begin st_d = PW_CONV; cnt_d = '0; end
      PW_CONV: begin
        if (eoc) begin
          cnt_d = '0;
          st_d  = (!srst_armed && !conv_lvl) ? PW_SLEEP : PW_READY;
        end else cnt_d = cnt_q + 1'b1;
      end
      PW_SLEEP: if (conv_rise) begin st_d = PW_WAKE; cnt_d = '0; end
      PW_WAKE: begin
        if (cnt_q == WAKE_LAST) begin st_d = PW_READY; cnt_d = '0; end
        else cnt_d = cnt_q + 1'b1;
      end
      default: st_d = PW_READY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= PW_READY;
      cnt_q      <= '0;
      result     <= '0;
      valid      <= 1'b0;
      seen_cmd_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (srst_exec) begin
        result     <= '0;
        valid      <= 1'b0;
        seen_cmd_q <= 1'b1;
      end else if (eoc) begin
        result <= core_code;
        valid  <= seen_cmd_q;
      end
    end
  end

  AST_SLEEP_AFTER_EOC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleeping) |-> $past(eoc)); // R3
  AST_WAKE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PW_WAKE) |=> (st_q != PW_CONV)); // R4
  AST_CONV_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt_q <= CONV_LAST)); // R2
  AST_CMD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    srst_exec |=> (result == '0) && !valid && !sleeping); // R9
endmodule

// File: rtl/sarc_serial.sv
module sarc_serial
  import sarc_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int ARM_LO = 2,
  parameter int ARM_HI = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_lvl,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sclk_fall,
  input  logic              conv_active,
  input  logic              eoc_busy,
  input  logic              srst_exec,
  input  logic [CODE_W-1:0] result,
  output logic              sdo_oe,
  output logic              sdo_bit,
  output logic              srst_armed
);
  localparam int NF_W = $clog2(CODE_W + 3);
  localparam int IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;
  localparam logic [NF_W-1:0] NF_MAX = '1;

  logic [NF_W-1:0] nfall_q;
  logic            busy_frame_q;
  logic [NF_W-1:0] nfall_inc;
  logic            frame_done;
  logic            in_window;
  logic [IDX_W-1:0] bit_idx;

  assign nfall_inc  = (nfall_q == NF_MAX) ? nfall_q : nfall_q + 1'b1;
  assign frame_done = (int'(nfall_inc) == int'(frame_last(busy_frame_q, CODE_W)));
  assign in_window  = (int'(nfall_q) >= ARM_LO) && (int'(nfall_q) <= ARM_HI);
  assign bit_idx    = IDX_W'(frame_bit(busy_frame_q, int'(nfall_q), CODE_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo_oe       <= 1'b0;
      busy_frame_q <= 1'b0;
      nfall_q      <= '0;
      srst_armed   <= 1'b0;
    end else begin
      if (srst_exec) srst_armed <= 1'b0;
      else if (cs_rise && in_window) srst_armed <= 1'b1;

      if (srst_exec) begin
        sdo_oe       <= 1'b0;
        busy_frame_q <= 1'b0;
        nfall_q      <= '0;
      end else if (eoc_busy) begin
        sdo_oe       <= 1'b1;
        busy_frame_q <= 1'b1;
        nfall_q      <= '0;
      end else if (cs_rise) begin
        sdo_oe <= 1'b0;
      end else if (cs_fall) begin
        nfall_q <= '0;
        if (!conv_active) begin
          sdo_oe       <= 1'b1;
          busy_frame_q <= 1'b0;
        end
      end else if (sclk_fall && !cs_lvl) begin
        nfall_q <= nfall_inc;
        if (frame_done) sdo_oe <= 1'b0;
      end
    end
  end

  always_comb begin
    sdo_bit = 1'b0;
    if (sdo_oe && !(busy_frame_q && nfall_q == '0)) sdo_bit = result[bit_idx];
  end

  AST_CS_RISE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !sdo_oe); // R8
  AST_FRAME_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> (int'(nfall_q) <= CODE_W)); // R6
  AST_ARM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(srst_armed) |-> $past(cs_rise) && (int'($past(nfall_q)) >= ARM_LO)
                          && (int'($past(nfall_q)) <= ARM_HI)); // R9
  AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo_bit); // R11
endmodule

// File: rtl/sar_ctl_serial.sv
module sar_ctl_serial #(
  parameter int CODE_W = 12,
  parameter int CONV_CYC = 33,
  parameter int PU_CYC = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic [CODE_W-1:0] core_code,
  output logic              sdo_oe,
  output logic              sdo_bit,
  output logic              conv_active,
  output logic              pd_state,
  output logic              res_valid
);
  localparam int PIN_CONV = 0;
  localparam int PIN_CS   = 1;
  localparam int PIN_SCLK = 2;

  logic [2:0] pin_lvl, pin_tgl;
  logic conv_fall, conv_rise, cs_fall, cs_rise, sclk_fall;
  logic eoc, eoc_busy, srst_exec, srst_armed;
  logic [CODE_W-1:0] result;

  sarc_sync #(.W(3), .STAGES(SYNC_STAGES), .IDLE_VAL(3'b011)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({sclk, cs_n, conv_n}),
    .lvl(pin_lvl), .tgl(pin_tgl)
  );

  assign conv_fall = pin_tgl[PIN_CONV] && !pin_lvl[PIN_CONV];
  assign conv_rise = pin_tgl[PIN_CONV] &&  pin_lvl[PIN_CONV];
  assign cs_fall   = pin_tgl[PIN_CS]   && !pin_lvl[PIN_CS];
  assign cs_rise   = pin_tgl[PIN_CS]   &&  pin_lvl[PIN_CS];
  assign sclk_fall = pin_tgl[PIN_SCLK] && !pin_lvl[PIN_SCLK];

  sarc_conv_ctrl #(.CODE_W(CODE_W), .CONV_CYC(CONV_CYC), .PU_CYC(PU_CYC)) u_conv (
    .clk(clk), .rst_n(rst_n),
    .conv_lvl(pin_lvl[PIN_CONV]), .conv_fall(conv_fall), .conv_rise(conv_rise),
    .cs_lvl(pin_lvl[PIN_CS]), .srst_armed(srst_armed), .core_code(core_code),
    .eoc(eoc), .eoc_busy(eoc_busy), .srst_exec(srst_exec),
    .result(result), .valid(res_valid), .active(conv_active), .sleeping(pd_state)
  );

  sarc_serial #(.CODE_W(CODE_W)) u_ser (
    .clk(clk), .rst_n(rst_n),
    .cs_lvl(pin_lvl[PIN_CS]), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_fall(sclk_fall), .conv_active(conv_active),
    .eoc_busy(eoc_busy), .srst_exec(srst_exec), .result(result),
    .sdo_oe(sdo_oe), .sdo_bit(sdo_bit), .srst_armed(srst_armed)
  );

  AST_EOC_ONLY_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> conv_active && !pd_state); // R2
endmodule

// File: tb/sar_ctl_serial_test.sv
module sar_ctl_serial_test;
  localparam int CW = 12;
  localparam int CONV = 33;
  localparam int PU = 5000;

  logic clk = 0;
  logic rst_n = 0;
  logic conv_n = 1, cs_n = 1, sclk = 0;
  logic [CW-1:0] core_code = '0;
  logic sdo_oe, sdo_bit, conv_active, pd_state, res_valid;

  int total = 0, bad = 0;
  // reference model state
  int exp_res = 0;
  bit cmd_done = 0, armed_m = 0, exp_pd = 0, exp_valid = 0;

  always #10 clk = ~clk;

  sar_ctl_serial #(.CODE_W(CW), .CONV_CYC(CONV), .PU_CYC(PU)) uut (
    .clk(clk), .rst_n(rst_n), .conv_n(conv_n), .cs_n(cs_n), .sclk(sclk),
    .core_code(core_code), .sdo_oe(sdo_oe), .sdo_bit(sdo_bit),
    .conv_active(conv_active), .pd_state(pd_state), .res_valid(res_valid)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wclk(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sclk_pulse();
    sclk = 1; wclk(4);
    sclk = 0; wclk(6);
  endtask

  task automatic model_eoc(int code, bit hold_low);
    if (armed_m) begin
      exp_res = 0; exp_valid = 0; exp_pd = 0; cmd_done = 1; armed_m = 0;
    end else begin
      exp_res = code; exp_valid = cmd_done; exp_pd = hold_low;
    end
  endtask

  // run one conversion; cs_low lowers select during the conversion
  task automatic convert(int code, bit hold_low, bit cs_low, string req);
    core_code = CW'(code);
    conv_n = 0; wclk(4);
    if (!hold_low) conv_n = 1;
    if (cs_low) cs_n = 0;
    wclk(6);
    chk({req, " conv_active mid"}, conv_active, 1);
    wclk(CONV + 4);
    model_eoc(code, hold_low);
    chk({req, " conv_active end"}, conv_active, 0);
    chk({req, " pd_state"}, pd_state, exp_pd);
    chk({req, " res_valid"}, res_valid, exp_valid);
  endtask

  // normal-framing read of nf falls
  task automatic read_nb(int nf, string req);
    cs_n = 0; wclk(6);
    chk({req, " oe at select"}, sdo_oe, 1);
    chk({req, " msb"}, sdo_bit, (exp_res >> (CW-1)) & 1);
    for (int k = 1; k <= nf; k++) begin
      sclk_pulse();
      if (k < CW) begin
        chk({req, " oe bit"}, sdo_oe, 1);
        chk({req, " bit"}, sdo_bit, (exp_res >> (CW-1-k)) & 1);
      end else chk({req, " release after last"}, sdo_oe, 0);
    end
    cs_n = 1; wclk(6);
    chk("R8 release on select rise", sdo_oe, 0);
    if (nf >= 2 && nf <= 8) armed_m = 1;
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog R1 act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wclk(3);
    chk("R1 oe", sdo_oe, 0);
    chk("R1 bit", sdo_bit, 0);
    chk("R1 active", conv_active, 0);
    chk("R1 pd", pd_state, 0);
    chk("R1 valid", res_valid, 0);
    rst_n = 1; wclk(4);

    // R2 R3 R10 normal conversion, no command yet so not valid
    convert('hA5C, 0, 0, "R2");
    read_nb(12, "R7");
    // R11 clock with select high
    sclk_pulse(); sclk_pulse();
    chk("R11 line idle", sdo_oe, 0);

    // R6 busy framing
    convert('h3F1, 0, 1, "R6");
    chk("R6 driven at end", sdo_oe, 1);
    chk("R6 low at end", sdo_bit, 0);
    for (int k = 1; k <= CW + 1; k++) begin
      sclk_pulse();
      if (k <= CW) begin
        chk("R6 oe", sdo_oe, 1);
        chk("R6 bit", sdo_bit, (exp_res >> (CW-k)) & 1);
      end else chk("R6 release on 13th", sdo_oe, 0);
    end
    cs_n = 1; wclk(6);

    // R9 abort after 2 falls arms; next end executes command
    read_nb(2, "R9 arm");
    convert('h777, 0, 1, "R9");
    chk("R9 no busy drive", sdo_oe, 0);
    chk("R10 not valid at command", res_valid, 0);
    cs_n = 1; wclk(6);
    read_nb(12, "R9 zero code");

    // R9 boundary: 9 falls arms nothing
    read_nb(9, "R9 nine");
    convert('hFFF, 0, 0, "R10");
    chk("R10 valid after command", res_valid, 1);
    read_nb(12, "R9 code kept");

    // R3 R5 sleep and read in sleep
    convert('h123, 1, 0, "R3");
    chk("R3 asleep", pd_state, 1);
    read_nb(12, "R5");
    // R4 wake-up blocks start edges
    conv_n = 1; wclk(100);
    conv_n = 0; wclk(4); conv_n = 1; wclk(6);
    chk("R4 ignored during wake", conv_active, 0);
    chk("R4 still waking", pd_state, 1);
    wclk(PU + 20);
    chk("R4 awake", pd_state, 0);
    convert('h800, 0, 0, "R4");
    read_nb(12, "R2 code");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule